// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two 80-bit extended-precision values: the top-of-stack operand and a second operand. It sorts the pair into one of four relations (greater, less, equal, unordered) and turns the result into either condition-code bits for the floating-point status word or arithmetic flags for the integer flag register. Alongside the compare it checks the tag-empty bits of both operands. An empty operand raises a stack fault. A NaN or an unsupported encoding can raise an invalid-operation exception. The block then applies the masked response or suppresses the update, and it reports how many stack pops the surrounding pipeline must perform.

The block does not hold the status word or the flag register itself. Each result is a registered value plus a per-bit write enable, valid for one cycle, one clock after the input strobe. The integrating core merges these into its own state. The block also supports a quiet mode and an ordered mode, a test-against-zero mode, and a hold of C1 for the quiet status-word register compare.

Top module: `fcmp_flag_unit`

## Requirements
- R1: A status-word result writes C0, C2 and C3 (cc bits 0, 2 and 3) as follows: greater gives 0,0,0; less gives C0 only; equal gives C3 only; unordered gives all three. cc_we bits 0, 2 and 3 are high on such a write, and the flags are not written.
- R2: An integer-flag result (to_flags=1) raises flags_we. The flags bit order is 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF. Greater clears all bits; less sets only CF; equal sets only ZF; unordered sets ZF, PF and CF. OF, SF and AF are always written as 0, and cc_we bits 0, 2 and 3 stay low.
- R3: Ordering is decided by sign first, then the 15-bit exponent, then the 64-bit significand. The magnitude order is inverted when both operands are negative, and +0 equals -0.
- R4: If either operand's empty bit is set, stk_fault and inv_pulse are raised. With inv_mask=1 the unordered code is written to the selected destination and the requested pops are issued. With inv_mask=0 nothing is written except C1, and pop_out is 0.
- R5: Any operand that is a NaN (exponent all ones, integer bit 1, fraction nonzero) or an unsupported encoding (nonzero exponent with integer bit 0) yields the unordered relation. The ordered mode (quiet=0) raises invalid on any such operand. The quiet mode raises invalid only for signalling NaNs (fraction bit 62 clear) and for unsupported encodings. With inv_mask=0, an invalid compare writes no code and issues no pop.
- R6: A completed compare returns pop_out equal to pop_req for requests 0, 1 and 2. A request of 3 is treated as 2.
- R7: Every accepted operation writes C1 as 0 (cc_we[1]=1, cc[1]=0). The one exception is when c1_keep=1 together with quiet=1, to_flags=0 and test_zero=0: then cc_we[1]=0.
- R8: With test_zero=1 the top of stack is compared with +0.0. op_b, b_empty and to_flags are ignored, the result goes to the status word, and pop_out is 0.
- R9: out_valid and all write enables, pulses and pops appear exactly one cycle after in_valid and are 0 in every other cycle. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 80 | Top-of-stack operand |
| op_b | input | 80 | Second operand |
| a_empty | input | 1 | Tag of op_a is empty |
| b_empty | input | 1 | Tag of op_b is empty |
| quiet | input | 1 | 1 = quiet compare, 0 = ordered compare |
| to_flags | input | 1 | 1 = integer flags destination, 0 = status word |
| test_zero | input | 1 | Compare op_a with +0.0 |
| c1_keep | input | 1 | Request to leave C1 unchanged (quiet register form) |
| pop_req | input | 2 | Requested pop count |
| inv_mask | input | 1 | Invalid-operation exception masked |
| out_valid | output | 1 | Result valid |
| cc | output | 4 | Condition code values {C3,C2,C1,C0} |
| cc_we | output | 4 | Per-bit write enables for cc |
| flags | output | 6 | Flag values {OF,SF,ZF,AF,PF,CF} |
| flags_we | output | 1 | Write enable for flags |
| inv_pulse | output | 1 | Invalid-operation exception raised |
| stk_fault | output | 1 | Stack underflow (empty operand) |
| pop_out | output | 2 | Pops to apply |

## Verification
Directed pairs separate the ordering stages. Operands that differ only in sign, only in exponent, or only in significand each show that the right stage decides the result. Equal negative pairs and the +0/-0 pair show the sign inversion and the zero rule. NaN, signalling-NaN and unsupported encodings are each run in quiet and ordered mode, masked and unmasked, which separates the two signalling rules and the suppression of writes and pops. Random pairs with a fixed seed mix every class, destination, pop count and mask setting against a bench reference.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  parameter int EXP_W = 15;
  parameter int SIG_W = 64;
  localparam int X_W  = 1 + EXP_W + SIG_W;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic sgn;
    logic zero;
    logic nan;
    logic snan;
    logic unsup;
  } cls_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int SW = SIG_W,
  localparam int XW = 1 + EW + SW
) (
  input  logic [XW-1:0] val,
  output cls_t          cls
);
  logic [EW-1:0] expo;
  logic [SW-1:0] sig;
  logic          jbit;

  assign expo = val[XW-2:SW];
  assign sig  = val[SW-1:0];
  assign jbit = sig[SW-1];

  always_comb begin
    cls.sgn   = val[XW-1];
    cls.zero  = (expo == '0) && (sig == '0);
    cls.unsup = (expo != '0) && !jbit;
    cls.nan   = (&expo) && jbit && (sig[SW-2:0] != '0);
    cls.snan  = cls.nan && !sig[SW-2];
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int SW = SIG_W,
  localparam int XW = 1 + EW + SW
) (
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  input  cls_t          ca,
  input  cls_t          cb,
  output rel_e          rel
);
  logic [XW-2:0] mag_a, mag_b;
  logic          unord;

  assign mag_a = a[XW-2:0];
  assign mag_b = b[XW-2:0];
  assign unord = ca.nan | cb.nan | ca.unsup | cb.unsup;

  always_comb begin
    if (unord)                     rel = REL_UN;
    else if (ca.zero && cb.zero)   rel = REL_EQ;
    else if (ca.sgn != cb.sgn)     rel = ca.sgn ? REL_LT : REL_GT;
    else if (mag_a == mag_b)       rel = REL_EQ;
    else if ((mag_a > mag_b) ^ ca.sgn) rel = REL_GT;
    else                           rel = REL_LT;
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int SW = SIG_W,
  parameter int POP_W = 2,
  localparam int XW = 1 + EW + SW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [XW-1:0]    op_a,
  input  logic [XW-1:0]    op_b,
  input  logic             a_empty,
  input  logic             b_empty,
  input  logic             quiet,
  input  logic             to_flags,
  input  logic             test_zero,
  input  logic             c1_keep,
  input  logic [POP_W-1:0] pop_req,
  input  logic             inv_mask,
  output logic             out_valid,
  output logic [3:0]       cc,
  output logic [3:0]       cc_we,
  output logic [5:0]       flags,
  output logic             flags_we,
  output logic             inv_pulse,
  output logic             stk_fault,
  output logic [POP_W-1:0] pop_out
);
  localparam logic [POP_W-1:0] POP_MAX = POP_W'(2);

  logic [XW-1:0] opnd [2];
  cls_t          cls  [2];
  rel_e          rel_raw, rel_use;

  assign opnd[0] = op_a;
  assign opnd[1] = test_zero ? '0 : op_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(.EW(EW), .SW(SW)) u_cls (.val(opnd[g]), .cls(cls[g]));
  end

  fcmp_order #(.EW(EW), .SW(SW)) u_ord (
    .a(opnd[0]), .b(opnd[1]), .ca(cls[0]), .cb(cls[1]), .rel(rel_raw)
  );

  logic             empty, sig_nan, raise, commit, dst_flags, hold_c1;
  logic [POP_W-1:0] pops;
  logic [3:0]       cc_code;
  logic [5:0]       fl_code;

  always_comb begin
    empty     = a_empty | (b_empty & ~test_zero);
    sig_nan   = cls[0].unsup | cls[1].unsup | cls[0].snan | cls[1].snan
              | (~quiet & (cls[0].nan | cls[1].nan));
    raise     = empty | sig_nan;
    commit    = ~raise | inv_mask;
    rel_use   = raise ? REL_UN : rel_raw;
    dst_flags = to_flags & ~test_zero;
    hold_c1   = c1_keep & quiet & ~to_flags & ~test_zero;
    if (test_zero)            pops = '0;
    else if (pop_req > POP_MAX) pops = POP_MAX;
    else                      pops = pop_req;
    unique case (rel_use)
      REL_GT: begin cc_code = 4'b0000; fl_code = 6'b000000; end
      REL_LT: begin cc_code = 4'b0001; fl_code = 6'b000001; end
      REL_EQ: begin cc_code = 4'b1000; fl_code = 6'b001000; end
      default: begin cc_code = 4'b1101; fl_code = 6'b001011; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cc        <= '0;
      cc_we     <= '0;
      flags     <= '0;
      flags_we  <= 1'b0;
      inv_pulse <= 1'b0;
      stk_fault <= 1'b0;
      pop_out   <= '0;
    end else begin
      out_valid <= in_valid;
      inv_pulse <= in_valid & raise;
      stk_fault <= in_valid & empty;
      pop_out   <= (in_valid & commit) ? pops : '0;
      cc        <= '0;
      cc_we     <= '0;
      flags     <= '0;
      flags_we  <= 1'b0;
      if (in_valid) begin
        cc_we[1] <= ~hold_c1;
        if (commit) begin
          if (dst_flags) begin
            flags    <= fl_code;
            flags_we <= 1'b1;
          end else begin
            cc[0]    <= cc_code[0];
            cc[2]    <= cc_code[2];
            cc[3]    <= cc_code[3];
            cc_we[0] <= 1'b1;
            cc_we[2] <= 1'b1;
            cc_we[3] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       test_zero,
  input logic       inv_mask,
  input logic       out_valid,
  input logic [3:0] cc,
  input logic [3:0] cc_we,
  input logic [5:0] flags,
  input logic       flags_we,
  input logic       inv_pulse,
  input logic       stk_fault,
  input logic [1:0] pop_out
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (cc_we == 4'b0 && !flags_we && pop_out == 2'd0 && !inv_pulse));

  a_r1_cc_code_legal: assert property (@(posedge clk) disable iff (rst)
    cc_we[0] |-> (cc[2] == (cc[0] & cc[3])));

  a_r2_flags_code_legal: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags[5:4] == 2'b00 && !flags[2] && flags[1] == (flags[0] & flags[3])));

  a_r5_unmasked_suppress: assert property (@(posedge clk) disable iff (rst)
    (inv_pulse && !$past(inv_mask)) |-> (!flags_we && cc_we[0] == 1'b0 && cc_we[3:2] == 2'b00 && pop_out == 2'd0));

  a_r4_fault_is_invalid: assert property (@(posedge clk) disable iff (rst)
    stk_fault |-> inv_pulse);

  a_r6_pop_range: assert property (@(posedge clk) disable iff (rst)
    pop_out != 2'd3);

  a_r8_test_no_pop: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(test_zero)) |-> (pop_out == 2'd0 && !flags_we));
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk u_chk (.*);

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 0;
  logic [79:0] op_a = '0, op_b = '0;
  logic        a_empty = 0, b_empty = 0, quiet = 0, to_flags = 0;
  logic        test_zero = 0, c1_keep = 0, inv_mask = 1;
  logic [1:0]  pop_req = 0;
  logic        out_valid, flags_we, inv_pulse, stk_fault;
  logic [3:0]  cc, cc_we;
  logic [5:0]  flags;
  logic [1:0]  pop_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fcmp_flag_unit u_dut (.*);

  function automatic logic [79:0] mk(bit s, logic [14:0] e, logic [63:0] m);
    return {s, e, m};
  endfunction

  function automatic bit f_nan(logic [79:0] x);
    return x[78:64] == 15'h7fff && x[63] && x[62:0] != 0;
  endfunction
  function automatic bit f_uns(logic [79:0] x);
    return x[78:64] != 0 && !x[63];
  endfunction
  function automatic bit f_snan(logic [79:0] x);
    return f_nan(x) && !x[62];
  endfunction

  // 0 greater, 1 less, 2 equal, 3 unordered
  function automatic int f_rel(logic [79:0] a, logic [79:0] b);
    if (f_nan(a) || f_nan(b) || f_uns(a) || f_uns(b)) return 3;
    if (a[78:0] == 0 && b[78:0] == 0) return 2;
    if (a[79] && !b[79]) return 1;
    if (!a[79] && b[79]) return 0;
    if (a[78:0] == b[78:0]) return 2;
    if (a[79]) return (a[78:0] < b[78:0]) ? 0 : 1;
    return (a[78:0] > b[78:0]) ? 0 : 1;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(string req, logic [79:0] a, logic [79:0] b, bit ae, bit be,
                     bit q, bit tf, bit tz, bit ck, logic [1:0] pr, bit msk);
    bit emp, sig, rse, com, dflag, hold;
    int r;
    logic [3:0] e_cc, e_we;
    logic [5:0] e_fl;
    logic [1:0] e_pop;
    logic [79:0] bb;
    bb  = tz ? 80'h0 : b;
    emp = ae || (be && !tz);
    sig = f_uns(a) || f_uns(bb) || f_snan(a) || f_snan(bb) || (!q && (f_nan(a) || f_nan(bb)));
    rse = emp || sig;
    com = !rse || msk;
    r   = rse ? 3 : f_rel(a, bb);
    dflag = tf && !tz;
    hold  = ck && q && !tf && !tz;
    e_cc = 0; e_we = 0; e_fl = 0;
    e_we[1] = !hold;
    e_pop = !com ? 2'd0 : tz ? 2'd0 : (pr == 3) ? 2'd2 : pr;
    if (com && !dflag) begin
      e_we[0] = 1; e_we[2] = 1; e_we[3] = 1;
      e_cc = (r == 3) ? 4'b1101 : (r == 1) ? 4'b0001 : (r == 2) ? 4'b1000 : 4'b0000;
    end
    if (com && dflag)
      e_fl = (r == 3) ? 6'b001011 : (r == 1) ? 6'b000001 : (r == 2) ? 6'b001000 : 6'b0;
    op_a = a; op_b = b; a_empty = ae; b_empty = be; quiet = q; to_flags = tf;
    test_zero = tz; c1_keep = ck; pop_req = pr; inv_mask = msk; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk(req, "valid", {7'b0, out_valid}, 8'd1);
    chk(req, "cc", {cc_we, cc}, {e_we, e_cc});
    chk(req, "flags", {1'b0, flags_we, flags}, {1'b0, com && dflag, e_fl});
    chk(req, "exc", {6'b0, inv_pulse, stk_fault}, {6'b0, rse, emp});
    chk(req, "pop", {6'b0, pop_out}, {6'b0, e_pop});
  endtask

  function automatic logic [79:0] rnd_op();
    logic [63:0] m;
    logic [14:0] e;
    int k;
    m = {$urandom, $urandom};
    k = $urandom % 10;
    e = 15'h3ff0 + 15'($urandom % 32);
    case (k)
      0: return mk($urandom % 2, 15'h7fff, {2'b11, m[61:0]});
      1: return mk($urandom % 2, 15'h7fff, {2'b10, m[61:1], 1'b1});
      2: return mk($urandom % 2, e, {1'b0, m[62:0]});
      3: return mk($urandom % 2, 15'h0, 64'h0);
      4: return mk($urandom % 2, 15'h7fff, 64'h8000_0000_0000_0000);
      default: return mk($urandom % 2, e, {1'b1, m[62:60], 60'h0});
    endcase
  endfunction

  localparam logic [79:0] ONE  = 80'h3fff_8000_0000_0000_0000;
  localparam logic [79:0] TWO  = 80'h4000_8000_0000_0000_0000;
  localparam logic [79:0] ONEP = 80'h3fff_c000_0000_0000_0000;
  localparam logic [79:0] QNAN = 80'h7fff_c000_0000_0000_0001;
  localparam logic [79:0] SNAN = 80'h7fff_8000_0000_0000_0001;
  localparam logic [79:0] UNSP = 80'h3fff_0000_0000_0000_0001;

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9", "reset", {out_valid, inv_pulse, stk_fault, flags_we, cc_we}, 8'h0);
    chk("R9", "reset pop", {2'b0, flags, 1'b0, 1'b0} | {6'b0, pop_out}, 8'h0);
    //    req   a     b     ae be q tf tz ck pr msk
    run("R1", ONE, TWO, 0, 0, 0, 0, 0, 0, 0, 1);
    run("R1", TWO, ONE, 0, 0, 0, 0, 0, 0, 0, 1);
    run("R1", ONE, ONE, 0, 0, 0, 0, 0, 0, 0, 1);
    run("R2", TWO, ONE, 0, 0, 0, 1, 0, 0, 0, 1);
    run("R2", ONE, TWO, 0, 0, 0, 1, 0, 0, 0, 1);
    run("R2", TWO, TWO, 0, 0, 1, 1, 0, 0, 0, 1);
    run("R3", ONE ^ (80'h1 << 79), TWO ^ (80'h1 << 79), 0, 0, 0, 0, 0, 0, 0, 1);
    run("R3", TWO ^ (80'h1 << 79), ONE, 0, 0, 0, 0, 0, 0, 0, 1);
    run("R3", 80'h0, 80'h1 << 79, 0, 0, 0, 1, 0, 0, 0, 1);
    run("R3", ONEP, ONE, 0, 0, 0, 0, 0, 0, 0, 1);
    run("R3", ONEP ^ (80'h1 << 79), ONE ^ (80'h1 << 79), 0, 0, 0, 0, 0, 0, 0, 1);
    run("R4", ONE, TWO, 1, 0, 0, 1, 0, 0, 1, 1);
    run("R4", ONE, TWO, 0, 1, 0, 0, 0, 0, 2, 0);
    run("R5", QNAN, ONE, 0, 0, 1, 0, 0, 0, 1, 0);
    run("R5", QNAN, ONE, 0, 0, 0, 0, 0, 0, 1, 1);
    run("R5", ONE, QNAN, 0, 0, 0, 1, 0, 0, 1, 0);
    run("R5", SNAN, ONE, 0, 0, 1, 1, 0, 0, 0, 1);
    run("R5", ONE, UNSP, 0, 0, 1, 0, 0, 0, 2, 0);
    run("R6", ONE, TWO, 0, 0, 0, 0, 0, 0, 2, 1);
    run("R6", ONE, TWO, 0, 0, 0, 0, 0, 0, 3, 1);
    run("R7", ONE, TWO, 0, 0, 1, 0, 0, 1, 0, 1);
    run("R7", ONE, TWO, 0, 0, 0, 0, 0, 1, 0, 1);
    run("R8", ONE ^ (80'h1 << 79), QNAN, 0, 1, 0, 1, 1, 1, 2, 0);
    run("R8", 80'h1 << 79, TWO, 0, 0, 0, 0, 1, 0, 1, 1);
    @(negedge clk);
    chk("R9", "idle", {out_valid, inv_pulse, flags_we, 1'b0, cc_we}, 8'h0);
    for (int i = 0; i < 3000; i++) begin
      run("R1", rnd_op(), rnd_op(), ($urandom % 16) == 0, ($urandom % 16) == 0,
          $urandom % 2, $urandom % 2, ($urandom % 8) == 0, $urandom % 2,
          2'($urandom % 4), ($urandom % 4) != 0);
      if ((i % 7) == 0) begin
        @(negedge clk);
        chk("R9", "gap", {7'b0, out_valid}, 8'd0);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule